// File: doc/BRIEF.md
# Paged Flash Chip-Select Address Mapper

This block sits between a processor's external-memory bus and an 8 MB flash device with a 16-bit data path. The bus has only 20 address lines but two flash chip selects. The mapper merges the two selects and a one-bit page register into one full flash word address. A 4 MB window of the processor's address space can therefore reach either half of the device. The second chip select supplies the top flash address bit, and the page register supplies the bit below it. The chip selects alias, so the processor sees the upper half of the first space followed by the lower half of the second as one continuous 4 MB region.

The page is changed by a write cycle to a separate control select. Bit 0 of the bus address during that write becomes the new page, and the data bus plays no part. A read cycle on the control select returns the current page on one data bit. A mode input picks 16-bit access, where bus addresses are word addresses, or 8-bit access, where the lowest bus address bit drives the flash byte-select line. A page change never disturbs a flash access that is already running: the access keeps the page it started with until its chip enable drops.

Top module: `paged_flash_mapper`

## Requirements
- R1: After reset the page is 0: `page_out` is 0, and a control read returns 0 on `ctl_rdata`.
- R2: A cycle with `ctl_sel` and `wr_en` both high sets the page to `bus_addr[0]` at the next rising clock edge. The other address bits have no effect.
- R3: A cycle with `ctl_sel` high and `wr_en` low leaves the page unchanged. During a read (`ctl_sel` and `rd_en` high), `ctl_rdata` equals the current page; at all other times it is 0.
- R4: `flash_ce` is high exactly when `fcs_a` or `fcs_b` is high.
- R5: In 16-bit mode (`wide_mode`=1), `flash_addr` = {`fcs_b`, page, `bus_addr[19:0]`} and `flash_byte_sel` is 0.
- R6: In 8-bit mode (`wide_mode`=0), `flash_addr` = {`fcs_b`, page, 1'b0, `bus_addr[19:1]`} and `flash_byte_sel` = `bus_addr[0]`.
- R7: If both flash chip selects are high, `fcs_b` wins and `flash_addr[21]` is 1.
- R8: While `flash_ce` stays high over consecutive cycles, `flash_addr[20]` keeps the page that was in force in the cycle the access began, even if the page changes meanwhile. The next access after `flash_ce` goes low uses the new page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 20 | Processor bus address lines |
| fcs_a | input | 1 | First flash chip select, active high |
| fcs_b | input | 1 | Second flash chip select, active high |
| ctl_sel | input | 1 | Control (page register) select, active high |
| wr_en | input | 1 | Write strobe, active high |
| rd_en | input | 1 | Read strobe, active high |
| wide_mode | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| flash_addr | output | 22 | Flash word address |
| flash_byte_sel | output | 1 | Flash byte-select line (8-bit mode) |
| flash_ce | output | 1 | Flash chip enable, active high |
| page_out | output | 1 | Current page register value |
| ctl_rdata | output | 1 | Page returned on control reads |

## Verification
The hardest case to reach is a page write that lands while a flash access is still running. On a normal bus the two cycles never overlap. The bench therefore holds a flash chip select high across several clock edges and pulses the control write inside that window, with address bit 0 set to the other page. It then checks two things: `page_out` moves at once while `flash_addr[20]` keeps the old page, and the old page is released only after the chip select has dropped for one cycle and risen again.

// File: rtl/flash_map_pkg.sv
package flash_map_pkg;
   // access width selected by the wide_mode input
   typedef enum logic {
      ACC_BYTE = 1'b0,
      ACC_WORD = 1'b1
   } acc_mode_e;
endpackage

// File: rtl/page_reg.sv
module page_reg (
   input  logic clk,
   input  logic rst,
   input  logic set_stb,
   input  logic new_page,
   output logic page_q
);
   always_ff @(posedge clk) begin
      if (rst)          page_q <= 1'b0;
      else if (set_stb) page_q <= new_page;
   end

   // R1: page comes out of reset as 0
   p_reset_page_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (page_q == 1'b0));
   // R2: strobe loads the selector bit
   p_load_page_r2: assert property (@(posedge clk) disable iff (rst)
      set_stb |=> (page_q == $past(new_page)));
   // R3: no strobe, no change
   p_hold_page_r3: assert property (@(posedge clk) disable iff (rst)
      !set_stb |=> $stable(page_q));
endmodule

// File: rtl/access_page_hold.sv
module access_page_hold (
   input  logic clk,
   input  logic rst,
   input  logic ce,
   input  logic live_page,
   output logic eff_page
);
   logic ce_q;
   logic held_q;

   // while an access continues, reuse the page seen when it began
   assign eff_page = (ce && ce_q) ? held_q : live_page;

   always_ff @(posedge clk) begin
      if (rst) begin
         ce_q   <= 1'b0;
         held_q <= 1'b0;
      end else begin
         ce_q   <= ce;
         held_q <= eff_page;
      end
   end
endmodule

// File: rtl/flash_addr_former.sv
module flash_addr_former
   import flash_map_pkg::*;
#(
   parameter int BUS_AW       = 20,
   parameter bit BYTE_MODE_EN = 1'b1,
   localparam int FLASH_AW    = BUS_AW + 2
) (
   input  logic [BUS_AW-1:0]   bus_addr,
   input  logic                upper_cs,
   input  logic                page,
   input  acc_mode_e           mode,
   output logic [FLASH_AW-1:0] faddr,
   output logic                byte_sel
);
   generate
      if (BYTE_MODE_EN) begin : g_dual
         always_comb begin
            if (mode == ACC_WORD) begin
               faddr    = {upper_cs, page, bus_addr};
               byte_sel = 1'b0;
            end else begin
               faddr    = {upper_cs, page, 1'b0, bus_addr[BUS_AW-1:1]};
               byte_sel = bus_addr[0];
            end
         end
      end else begin : g_word_only
         logic unused_mode;
         assign unused_mode = (mode == ACC_BYTE);
         assign faddr    = {upper_cs, page, bus_addr};
         assign byte_sel = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/paged_flash_mapper.sv
module paged_flash_mapper
   import flash_map_pkg::*;
#(
   parameter int BUS_AW       = 20,
   parameter bit BYTE_MODE_EN = 1'b1,
   localparam int FLASH_AW    = BUS_AW + 2,
   localparam int PAGE_BIT    = BUS_AW
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [BUS_AW-1:0]   bus_addr,
   input  logic                fcs_a,
   input  logic                fcs_b,
   input  logic                ctl_sel,
   input  logic                wr_en,
   input  logic                rd_en,
   input  logic                wide_mode,
   output logic [FLASH_AW-1:0] flash_addr,
   output logic                flash_byte_sel,
   output logic                flash_ce,
   output logic                page_out,
   output logic                ctl_rdata
);
   initial begin
      if (BUS_AW < 2) $error("BUS_AW must be at least 2");
   end

   logic      page_live;
   logic      page_eff;
   acc_mode_e mode;

   assign flash_ce  = fcs_a | fcs_b;
   assign mode      = wide_mode ? ACC_WORD : ACC_BYTE;
   assign page_out  = page_live;
   assign ctl_rdata = ctl_sel & rd_en & page_live;

   page_reg u_page (
      .clk      (clk),
      .rst      (rst),
      .set_stb  (ctl_sel & wr_en),
      .new_page (bus_addr[0]),
      .page_q   (page_live)
   );

   access_page_hold u_hold (
      .clk       (clk),
      .rst       (rst),
      .ce        (flash_ce),
      .live_page (page_live),
      .eff_page  (page_eff)
   );

   flash_addr_former #(
      .BUS_AW       (BUS_AW),
      .BYTE_MODE_EN (BYTE_MODE_EN)
   ) u_form (
      .bus_addr (bus_addr),
      .upper_cs (fcs_b),
      .page     (page_eff),
      .mode     (mode),
      .faddr    (flash_addr),
      .byte_sel (flash_byte_sel)
   );

   // R8: page bit frozen across a continuing access
   p_frozen_page_r8: assert property (@(posedge clk) disable iff (rst)
      (flash_ce && $past(flash_ce)) |->
         (flash_addr[PAGE_BIT] == $past(flash_addr[PAGE_BIT])));
   // R8: a fresh access starts with the live page
   p_fresh_page_r8: assert property (@(posedge clk) disable iff (rst)
      $rose(flash_ce) |-> (flash_addr[PAGE_BIT] == page_out));
endmodule

// File: tb/paged_flash_mapper_tb.sv
module paged_flash_mapper_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [19:0] bus_addr = '0;
   logic        fcs_a = 1'b0, fcs_b = 1'b0;
   logic        ctl_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic        wide_mode = 1'b1;
   logic [21:0] flash_addr;
   logic        flash_byte_sel, flash_ce, page_out, ctl_rdata;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   paged_flash_mapper u_dut (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .fcs_a(fcs_a), .fcs_b(fcs_b),
      .ctl_sel(ctl_sel), .wr_en(wr_en), .rd_en(rd_en), .wide_mode(wide_mode),
      .flash_addr(flash_addr), .flash_byte_sel(flash_byte_sel),
      .flash_ce(flash_ce), .page_out(page_out), .ctl_rdata(ctl_rdata)
   );

   typedef struct packed {
      logic        page;
      logic        cs_a;
      logic        cs_b;
      logic        wide;
      logic [19:0] addr;
      logic [21:0] exp_addr;
      logic        exp_bs;
      logic        exp_ce;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 1'b1, 1'b0, 1'b1, 20'h12345, 22'h012345, 1'b0, 1'b1},  // R5
      '{1'b0, 1'b0, 1'b1, 1'b1, 20'hFFFFF, 22'h2FFFFF, 1'b0, 1'b1},  // R5
      '{1'b1, 1'b1, 1'b0, 1'b1, 20'h00001, 22'h100001, 1'b0, 1'b1},  // R5
      '{1'b1, 1'b0, 1'b1, 1'b1, 20'hABCDE, 22'h3ABCDE, 1'b0, 1'b1},  // R5
      '{1'b0, 1'b1, 1'b0, 1'b0, 20'h12345, 22'h0091A2, 1'b1, 1'b1},  // R6
      '{1'b1, 1'b0, 1'b1, 1'b0, 20'hFFFFE, 22'h37FFFF, 1'b0, 1'b1},  // R6
      '{1'b1, 1'b1, 1'b1, 1'b1, 20'h00400, 22'h300400, 1'b0, 1'b1},  // R7
      '{1'b0, 1'b0, 1'b0, 1'b1, 20'h55555, 22'h000000, 1'b0, 1'b0}   // R4
   };

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   // drive at the falling edge, let one rising edge pass
   task automatic cycle();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      fcs_a = 0; fcs_b = 0; ctl_sel = 0; wr_en = 0; rd_en = 0;
   endtask

   task automatic set_page(input logic [19:0] a);
      idle();
      bus_addr = a; ctl_sel = 1; wr_en = 1;
      cycle();
      idle();
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      finish_up();
   end

   initial begin
      @(negedge clk);
      cycle(); cycle();
      rst = 0;
      #2;
      check(page_out == 1'b0, "R1 page after reset", page_out, 0);
      ctl_sel = 1; rd_en = 1; #1;
      check(ctl_rdata == 1'b0, "R1 read after reset", ctl_rdata, 0);
      idle();
      @(negedge clk);

      // table of mapping vectors
      for (int i = 0; i < NV; i++) begin
         set_page({19'h7FFFF, VEC[i].page});
         check(page_out == VEC[i].page, "R2 page set by address bit 0",
               page_out, VEC[i].page);
         bus_addr = VEC[i].addr; fcs_a = VEC[i].cs_a; fcs_b = VEC[i].cs_b;
         wide_mode = VEC[i].wide;
         #2;
         check(flash_ce == VEC[i].exp_ce, "R4 chip enable", flash_ce, VEC[i].exp_ce);
         if (VEC[i].exp_ce) begin
            check(flash_addr == VEC[i].exp_addr, "R5/R6/R7 flash address",
                  flash_addr, VEC[i].exp_addr);
            check(flash_byte_sel == VEC[i].exp_bs, "R5/R6 byte select",
                  flash_byte_sel, VEC[i].exp_bs);
         end
         cycle();
         idle();
         cycle();
      end
      wide_mode = 1;

      // R2: upper address bits ignored, bit 0 decides
      set_page(20'h00001);
      check(page_out == 1'b1, "R2 page 1", page_out, 1);
      set_page(20'hFFFFE);
      check(page_out == 1'b0, "R2 page 0 despite high bits", page_out, 0);

      // R3: reads and idle cycles leave page alone
      set_page(20'h00001);
      bus_addr = 20'h00000; ctl_sel = 1; rd_en = 1;
      #1;
      check(ctl_rdata == 1'b1, "R3 read returns page", ctl_rdata, 1);
      cycle();
      check(page_out == 1'b1, "R3 read with bit0=0 keeps page", page_out, 1);
      idle(); bus_addr = 20'h00000;
      cycle(); cycle();
      check(page_out == 1'b1, "R3 idle keeps page", page_out, 1);
      #1;
      check(ctl_rdata == 1'b0, "R3 no read, rdata low", ctl_rdata, 0);

      // R8: page write in the middle of a running access
      set_page(20'h00000);
      bus_addr = 20'h00011; fcs_a = 1;
      #1;
      check(flash_addr[20] == 1'b0, "R8 access starts on page 0", flash_addr[20], 0);
      cycle();
      ctl_sel = 1; wr_en = 1;   // bus_addr[0]=1 selects page 1
      cycle();
      ctl_sel = 0; wr_en = 0;
      #1;
      check(page_out == 1'b1, "R8 page register moved", page_out, 1);
      check(flash_addr[20] == 1'b0, "R8 running access keeps old page",
            flash_addr[20], 0);
      cycle();
      #1;
      check(flash_addr[20] == 1'b0, "R8 still old page", flash_addr[20], 0);
      fcs_a = 0;
      cycle();
      fcs_a = 1;
      #1;
      check(flash_addr[20] == 1'b1, "R8 next access uses new page",
            flash_addr[20], 1);
      idle();
      cycle();

      // R1: reset returns the page to 0
      rst = 1;
      cycle();
      rst = 0;
      #1;
      check(page_out == 1'b0, "R1 page cleared by reset", page_out, 0);
      cycle();
      finish_up();
   end
endmodule